// File: doc/BRIEF.md
# Register-List Stack Push Sequencer

This block carries out a frame-setup instruction over several cycles. When `start` arrives with a recognised encoding, it latches a 12-bit register mask, a 5-bit frame size and the form of the instruction. It then writes each selected general register to the stack, one 32-bit word per memory handshake, lowering the stack pointer by four for each word. After the last word it allocates the frame by subtracting the frame size from the stack pointer. In the extended form it also loads the element pointer from the new stack pointer or from an immediate that follows the instruction.

The surrounding pipeline provides the current stack pointer and the trailing immediate, and serves register reads combinationally from `rf_raddr`. It commits the `sp_we` and `ep_we` strobes to its own register file. `done` marks the cycle in which the last of these updates commits.

Top module: `stkpush_seq`

## Requirements
- R1: `start` is accepted only while idle and only when `insn[31:22]` is `0000011110` and either `insn[4:0]` is `00001` (plain form) or `insn[2:0]` is `011` (extended form). Any other `start` leaves the block idle, with no write, no strobe and no `done`.
- R2: The mask is built as bit 0 = `insn[16]` and bits 11..1 = `insn[15:5]`. With the default map, mask bit k stores general register 20+k.
- R3: Words are pushed from the highest set mask bit down to the lowest. Push j (counting from 1) writes the register value to address sp-4j, and `sp_we` carries that same address when the write is accepted.
- R4: A write with `mem_ready` low is held, with address and data unchanged, until `mem_ready` is high. Only then does the next push start.
- R5: After the pushes, `sp_we` carries the stack pointer minus the zero-extended `insn[21:17]`.
- R6: In the extended form, `insn[4:3]` selects the element pointer value. 00 selects the allocated sp. 01 selects `ext_imm[15:0]` sign-extended. 10 selects `ext_imm[15:0]` shifted left by 16. 11 selects all of `ext_imm`.
- R7: With `mem_ready` held high, `done` occurs n+1 cycles after the accepting edge for the plain form and n+2 cycles for the extended form, where n is the number of set mask bits.
- R8: `done` is a one-cycle pulse in the cycle of the final register update. `ep_we` appears only in the extended form and only together with `done`.
- R9: An all-zero mask issues no memory write and goes straight to frame allocation.
- R10: After reset the block is idle, with `busy`, `mem_wr`, `sp_we`, `ep_we` and `done` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Instruction valid |
| insn | input | 32 | Instruction, first halfword in bits 31:16 |
| ext_imm | input | 32 | Trailing immediate, 16-bit forms in bits 15:0 |
| sp_in | input | 32 | Stack pointer at issue |
| busy | output | 1 | Sequence in progress |
| rf_raddr | output | 5 | Register read index |
| rf_rdata | input | 32 | Register read data |
| mem_wr | output | 1 | Word write request |
| mem_addr | output | 32 | Write address |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Write accepted this cycle |
| sp_we | output | 1 | Stack pointer update strobe |
| sp_wdata | output | 32 | New stack pointer value |
| ep_we | output | 1 | Element pointer update strobe |
| ep_wdata | output | 32 | New element pointer value |
| done | output | 1 | Final update commits this cycle |

## Verification
The bench sweeps all 4096 masks in the plain form, which covers the empty mask and the full mask. A picker with the wrong priority, or a lost L bit, would push registers in the wrong order or skip a register. All four element pointer sources are driven with immediates whose bit 15 is set. This exposes a zero-extension in place of a sign-extension, or a source taken before the frame is allocated. Stalled handshakes check that a pending write is not dropped or advanced early. A second `start` while busy, and encodings with a wrong opcode or tail, must change nothing.

// File: rtl/stkpush_pkg.sv
// Shared constants and types for the stack push sequencer.
// Assumes the fixed 32-bit instruction layout described in the brief.
package stkpush_pkg;
    localparam int LIST_W  = 12;
    localparam int REG_AW  = 5;
    localparam int FRAME_W = 5;
    localparam int IDX_W   = $clog2(LIST_W);

    typedef enum logic [1:0] {ST_IDLE, ST_PUSH, ST_ALLOC, ST_EPLD} seq_state_e;
    typedef enum logic [1:0] {EP_FROM_SP, EP_SEXT16, EP_HIGH16, EP_IMM32} ep_src_e;

    typedef struct packed {
        logic               valid;
        logic               ep_form;
        ep_src_e            ep_src;
        logic [FRAME_W-1:0] frame;
        logic [LIST_W-1:0]  mask;
    } frame_cmd_t;

    // Default mask-bit to register map: bit k selects register 20+k.
    function automatic logic [LIST_W*REG_AW-1:0] default_reg_map();
        logic [LIST_W*REG_AW-1:0] m;
        for (int k = 0; k < LIST_W; k++) m[k*REG_AW +: REG_AW] = REG_AW'(20 + k);
        return m;
    endfunction
endpackage

// File: rtl/stkpush_decode.sv
// Field extraction and legality check for the frame-setup instruction.
// Purely combinational; assumes the first halfword sits in insn[31:16].
module stkpush_decode
    import stkpush_pkg::*;
(
    input  logic [31:0] insn,
    output frame_cmd_t  cmd
);
    // Decode the opcode, form selector and the list/frame fields.
    always_comb begin
        cmd.ep_form = (insn[2:0] == 3'b011);
        cmd.valid   = (insn[31:22] == 10'b0000011110) &&
                      ((insn[4:0] == 5'b00001) || cmd.ep_form);
        cmd.ep_src  = ep_src_e'(insn[4:3]);
        cmd.frame   = insn[21:17];
        cmd.mask    = {insn[15:5], insn[16]};
    end
endmodule

// File: rtl/stkpush_pick.sv
// Picks the highest set bit of a vector. any is low when the vector is zero.
// Assumes W >= 2.
module stkpush_pick #(
    parameter int W   = 12,
    localparam int IW = $clog2(W)
) (
    input  logic [W-1:0]  bits,
    output logic          any,
    output logic [IW-1:0] idx
);
    // Scan upward so the highest set bit wins.
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = 0; i < W; i++) begin
            if (bits[i]) begin
                any = 1'b1;
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/stkpush_epsel.sv
// Element pointer source selector. Assumes DATA_W >= 32.
module stkpush_epsel
    import stkpush_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  ep_src_e           src,
    input  logic [DATA_W-1:0] sp_val,
    input  logic [DATA_W-1:0] imm,
    output logic [DATA_W-1:0] ep
);
    // Form the element pointer value from the chosen source.
    always_comb begin
        unique case (src)
            EP_FROM_SP: ep = sp_val;
            EP_SEXT16:  ep = {{(DATA_W-16){imm[15]}}, imm[15:0]};
            EP_HIGH16:  ep = DATA_W'({imm[15:0], 16'h0000});
            default:    ep = imm;
        endcase
    end
endmodule

// File: rtl/stkpush_seq.sv
// Frame-setup sequencer. It pushes the registers selected by the mask,
// allocates the frame and, in the extended form, loads the element pointer.
// Assumes a combinational register read and a memory that takes a write in
// any cycle where mem_wr and mem_ready are both high.
module stkpush_seq
    import stkpush_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter logic [LIST_W*REG_AW-1:0] REG_MAP = default_reg_map()
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [31:0]       insn,
    input  logic [DATA_W-1:0] ext_imm,
    input  logic [DATA_W-1:0] sp_in,
    output logic              busy,
    output logic [REG_AW-1:0] rf_raddr,
    input  logic [DATA_W-1:0] rf_rdata,
    output logic              mem_wr,
    output logic [DATA_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ready,
    output logic              sp_we,
    output logic [DATA_W-1:0] sp_wdata,
    output logic              ep_we,
    output logic [DATA_W-1:0] ep_wdata,
    output logic              done
);
    localparam logic [DATA_W-1:0] WORD_BYTES = DATA_W'(4);

    seq_state_e         state_q;
    logic [LIST_W-1:0]  mask_q, mask_rest;
    logic [FRAME_W-1:0] frame_q;
    logic               ep_form_q;
    ep_src_e            ep_src_q;
    logic [DATA_W-1:0]  imm_q, sp_q;
    logic [DATA_W-1:0]  push_addr, alloc_sp;
    frame_cmd_t         cmd;
    logic               pick_any;
    logic [IDX_W-1:0]   pick_idx;

    stkpush_decode u_dec (.insn(insn), .cmd(cmd));

    stkpush_pick #(.W(LIST_W)) u_pick (.bits(mask_q), .any(pick_any), .idx(pick_idx));

    stkpush_epsel #(.DATA_W(DATA_W)) u_ep (
        .src(ep_src_q), .sp_val(sp_q), .imm(imm_q), .ep(ep_wdata)
    );

    // Next stack addresses for a push and for the frame allocation.
    always_comb begin
        push_addr = sp_q - WORD_BYTES;
        alloc_sp  = sp_q - {{(DATA_W-FRAME_W){1'b0}}, frame_q};
    end

    // Mask with the bit being pushed now removed.
    always_comb begin
        mask_rest           = mask_q;
        mask_rest[pick_idx] = 1'b0;
    end

    // Drive the outputs from the current state.
    always_comb begin
        busy      = (state_q != ST_IDLE);
        rf_raddr  = REG_MAP[pick_idx*REG_AW +: REG_AW];
        mem_wr    = (state_q == ST_PUSH) && pick_any;
        mem_addr  = push_addr;
        mem_wdata = rf_rdata;
        sp_we     = (mem_wr && mem_ready) || (state_q == ST_ALLOC);
        sp_wdata  = (state_q == ST_ALLOC) ? alloc_sp : push_addr;
        ep_we     = (state_q == ST_EPLD);
        done      = (state_q == ST_EPLD) || ((state_q == ST_ALLOC) && !ep_form_q);
    end

    // Sequence control, operand capture and stack pointer tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            mask_q    <= '0;
            frame_q   <= '0;
            ep_form_q <= 1'b0;
            ep_src_q  <= EP_FROM_SP;
            imm_q     <= '0;
            sp_q      <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start && cmd.valid) begin
                        mask_q    <= cmd.mask;
                        frame_q   <= cmd.frame;
                        ep_form_q <= cmd.ep_form;
                        ep_src_q  <= cmd.ep_src;
                        imm_q     <= ext_imm;
                        sp_q      <= sp_in;
                        state_q   <= (cmd.mask == '0) ? ST_ALLOC : ST_PUSH;
                    end
                end
                ST_PUSH: begin
                    if (mem_wr && mem_ready) begin
                        mask_q <= mask_rest;
                        sp_q   <= push_addr;
                        if (mask_rest == '0) state_q <= ST_ALLOC;
                    end
                end
                ST_ALLOC: begin
                    sp_q    <= alloc_sp;
                    state_q <= ep_form_q ? ST_EPLD : ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/stkpush_seq_chk.sv
// Protocol checks for stkpush_seq, attached by bind.
module stkpush_seq_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              mem_wr,
    input logic              mem_ready,
    input logic [DATA_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              sp_we,
    input logic [DATA_W-1:0] sp_wdata,
    input logic              ep_we,
    input logic              done
);
    a_r4_hold_write: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && !mem_ready) |=> (mem_wr && $stable(mem_addr) && $stable(mem_wdata)));

    a_r3_push_sp: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && mem_ready) |-> (sp_we && sp_wdata == mem_addr));

    a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && mem_ready) |=> (!mem_wr || mem_addr == $past(mem_addr) - DATA_W'(4)));

    a_r8_ep_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        ep_we |-> done);

    a_r8_done_ends: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_wr && !sp_we && !ep_we && !done));
endmodule

bind stkpush_seq stkpush_seq_chk #(.DATA_W(DATA_W)) chk_i (.*);

// File: tb/stkpush_seq_tb.sv
`timescale 1ns/1ps
module stkpush_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] insn = '0;
    logic [31:0] ext_imm = '0;
    logic [31:0] sp_in = '0;
    logic        busy;
    logic [4:0]  rf_raddr;
    logic [31:0] rf_rdata;
    logic        mem_wr;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ready = 1'b1;
    logic        sp_we, ep_we, done;
    logic [31:0] sp_wdata, ep_wdata;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    function automatic logic [31:0] rfval(input logic [4:0] r);
        return 32'h5A00_0000 | ({27'd0, r} << 16) | (32'h0000_0F0F ^ {27'd0, r});
    endfunction

    assign rf_rdata = rfval(rf_raddr);

    stkpush_seq dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .insn(insn), .ext_imm(ext_imm),
        .sp_in(sp_in), .busy(busy), .rf_raddr(rf_raddr), .rf_rdata(rf_rdata),
        .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ready(mem_ready), .sp_we(sp_we), .sp_wdata(sp_wdata),
        .ep_we(ep_we), .ep_wdata(ep_wdata), .done(done)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [11:0] m, input logic [4:0] fr,
                                       input bit epf, input logic [1:0] ff);
        return {5'b00000, 5'b11110, fr, m[0], m[11:1], epf ? {ff, 3'b011} : 5'b00001};
    endfunction

    // One instruction: stall slows mem_ready, poke retries start while busy.
    task automatic run(input logic [11:0] m, input logic [4:0] fr, input bit epf,
                       input logic [1:0] ff, input logic [31:0] imm, input logic [31:0] sp0,
                       input bit stall, input bit poke);
        int n = 0, wr = 0, k = 11, cyc = 1;
        bit got_done = 0, ep_seen = 0;
        logic [31:0] last_sp = sp0, ep_got = '0, exp_sp, exp_ep;
        for (int i = 0; i < 12; i++) n += m[i];
        exp_sp = sp0 - 32'(4 * n) - {27'd0, fr};
        case (ff)
            2'd0: exp_ep = exp_sp;
            2'd1: exp_ep = {{16{imm[15]}}, imm[15:0]};
            2'd2: exp_ep = {imm[15:0], 16'h0};
            default: exp_ep = imm;
        endcase
        @(negedge clk);
        start = 1; insn = mk(m, fr, epf, ff); ext_imm = imm; sp_in = sp0; mem_ready = 1;
        @(negedge clk);
        start = 0;
        while (!got_done && cyc < 200) begin
            mem_ready = stall ? (cyc % 3 == 0) : 1'b1;
            if (poke && cyc == 2) begin
                start = 1; insn = mk(12'hFFF, 5'd7, 1'b1, 2'd3);
            end else start = 0;
            #1;
            if (mem_wr && mem_ready) begin
                while (k >= 0 && !m[k]) k--;
                // R2 R3: order, address and register value of each push
                chk(k >= 0 && mem_addr == sp0 - 32'(4 * (wr + 1)) && mem_wdata == rfval(5'(20 + k)),
                    "R3 push", mem_addr, sp0 - 32'(4 * (wr + 1)));
                wr++; k--;
            end
            if (sp_we) last_sp = sp_wdata;
            if (ep_we) begin ep_seen = 1; ep_got = ep_wdata; end
            if (done) got_done = 1;
            else begin @(negedge clk); cyc++; end
        end
        start = 0;
        chk(got_done, "R8 done seen", 32'(got_done), 32'd1);
        chk(wr == n, m == 0 ? "R9 empty mask writes" : "R3 write count", 32'(wr), 32'(n));
        chk(last_sp == exp_sp, "R5 final sp", last_sp, exp_sp);
        chk(ep_seen == epf, "R8 ep strobe", 32'(ep_seen), 32'(epf));
        if (epf) chk(ep_got == exp_ep, "R6 ep value", ep_got, exp_ep);
        if (!stall) chk(cyc == n + 1 + int'(epf), "R7 cycles", 32'(cyc), 32'(n + 1 + int'(epf)));
        @(negedge clk); #1;
        chk(!busy && !done, "R8 idle after done", 32'(busy), 32'd0);
    endtask

    // Illegal encoding must leave the block idle.
    task automatic bad(input logic [31:0] code);
        bit quiet = 1;
        @(negedge clk);
        start = 1; insn = code; ext_imm = 32'h1234; sp_in = 32'h100;
        @(negedge clk);
        start = 0;
        for (int i = 0; i < 4; i++) begin
            #1;
            if (busy || mem_wr || sp_we || ep_we || done) quiet = 0;
            @(negedge clk);
        end
        chk(quiet, "R1 illegal ignored", code, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk(!busy && !mem_wr && !sp_we && !ep_we && !done, "R10 reset state", 32'(busy), 32'd0);
        rst_n = 1;
        // R2 R3 R5 R7 R9: every mask in the plain form
        for (int m = 0; m < 4096; m++)
            run(12'(m), 5'(m) ^ 5'(m >> 7), 1'b0, 2'd0, 32'h0, 32'h2000_0000 - 32'(m << 4), 1'b0, 1'b0);
        // R6 R7: all element pointer sources
        for (int f = 0; f < 4; f++) begin
            run(12'h000, 5'd31, 1'b1, 2'(f), 32'hCAFE_9ABC, 32'h0000_8000, 1'b0, 1'b0);
            run(12'h801, 5'd4, 1'b1, 2'(f), 32'h1357_8642, 32'h0010_0000, 1'b0, 1'b0);
            run(12'hFFF, 5'd17, 1'b1, 2'(f), 32'h0BAD_F00D, 32'h0000_0100, 1'b0, 1'b0);
        end
        // R4: stalled handshakes
        for (int m = 0; m < 4096; m += 257)
            run(12'(m), 5'd9, 1'b1, 2'(m & 3), 32'h8001_FFFF, 32'h4000_0000, 1'b1, 1'b0);
        // R1: start while busy ignored
        run(12'h0A5, 5'd2, 1'b0, 2'd0, 32'h0, 32'h3000, 1'b1, 1'b1);
        // R1: wrong opcode and wrong tail
        bad(32'h07C0_0001 ^ 32'h0100_0000);
        bad({5'b00000, 5'b11110, 5'd3, 1'b1, 11'h7FF, 5'b00010});
        bad({5'b00001, 5'b11110, 5'd3, 1'b1, 11'h7FF, 5'b00001});
        if (!finished) begin
            finished = 1;
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule